// File: doc/BRIEF.md
# Software Interrupt Doorbell Array

This block raises software interrupts between processors. Each of the `NUM_HARTS` harts owns one 32-bit doorbell word in a small register window. A processor that wants to interrupt a peer writes a 1 into that peer's word. The block drives the peer's interrupt line from a pending bit that it keeps for each hart. Words sit back to back, four bytes apart, from offset 0. The hart served by a word is its byte offset divided by four.

The `MODE` parameter picks one of two behaviours at build time. In machine mode each word is an ordinary pending flag: writing 0 clears it, and a read returns the flag in bit 0. In supervisor mode a word is a set-only doorbell. Writing 0 does nothing and reads always return zero. The flag is cleared only when the receiving hart pulses its own acknowledge input. The register port takes 32-bit accesses only, marked by all four byte enables. Every read request, valid or not, is answered exactly one cycle later.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset every interrupt output is 0 and no read response is pending.
- R2: A full-width write whose data bit 0 is 1 to byte offset 4*k (k < NUM_HARTS) raises interrupt output k after one clock edge in both modes. Data bits 31..1 have no effect.
- R3: In machine mode, a full-width write with data bit 0 equal to 0 to offset 4*k lowers interrupt output k.
- R4: Every read request is answered with a one-cycle rsp_valid pulse on the following cycle. In machine mode the read data carries the addressed hart's pending flag in bit 0 and zeros in bits 31..1.
- R5: A request whose address has bits 1..0 not zero, or whose word index is NUM_HARTS or more, changes no output when it is a write and returns 0 when it is a read.
- R6: A request whose byte enable is not 4'b1111 changes no output when it is a write and returns 0 when it is a read.
- R7: In supervisor mode, writing data bit 0 equal to 0 leaves the addressed interrupt output unchanged.
- R8: In supervisor mode every read returns 0.
- R9: In supervisor mode, a 1 on ack_i[k] lowers interrupt output k after one clock edge. If a valid set to hart k arrives in the same cycle, the set wins and the output stays high.
- R10: In machine mode the ack_i inputs have no effect on any output.
- R11: A write to hart k never changes the interrupt output of any other hart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Register request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset in the window |
| req_wdata_i | input | 32 | Write data; only bit 0 is used |
| req_be_i | input | 4 | Byte enables; must be 4'b1111 for a valid access |
| rsp_valid_o | output | 1 | Read response strobe, one cycle after a read |
| rsp_rdata_o | output | 32 | Read response data |
| ack_i | input | NUM_HARTS | Per-hart acknowledge (supervisor mode) |
| swi_o | output | NUM_HARTS | Per-hart software interrupt |

## Verification
In supervisor mode, a register write that sets hart k can land in the same cycle as that hart's acknowledge. The bench drives both on one falling edge, with the write aimed at hart 1 and acknowledges raised on several harts. It then expects hart 1 to stay set and the other acknowledged harts to clear. In the same cycle a machine-mode copy on the same bus receives all-ones acknowledges, and the bench checks that none of its lines moves.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;

    typedef enum logic {
        MODE_MACHINE    = 1'b0,
        MODE_SUPERVISOR = 1'b1
    } swi_mode_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 1,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [BE_W-1:0]      req_be_i,
    output logic [NUM_HARTS-1:0] wr_hit_o,
    output logic [NUM_HARTS-1:0] rd_hit_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             in_range;
    logic             full_word;
    logic             legal;

    always_comb begin
        word_idx  = req_addr_i[ADDR_W-1:2];
        aligned   = (req_addr_i[1:0] == 2'b00);
        in_range  = ({1'b0, word_idx} < (IDX_W+1)'(NUM_HARTS));
        full_word = (req_be_i == {BE_W{1'b1}});
        legal     = req_valid_i & aligned & in_range & full_word;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
        logic sel;
        assign sel         = legal & (word_idx == IDX_W'(h));
        assign wr_hit_o[h] = sel & req_write_i;
        assign rd_hit_o[h] = sel & ~req_write_i;
    end

endmodule

// File: rtl/ipi_pend_cell.sv
module ipi_pend_cell
    import ipi_pkg::*;
#(
    parameter swi_mode_e MODE = MODE_MACHINE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_hit_i,
    input  logic wr_bit_i,
    input  logic ack_i,
    output logic pend_o
);

    typedef struct packed {
        logic pend;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (MODE == MODE_MACHINE) begin
            if (wr_hit_i) begin
                st_d.pend = wr_bit_i;
            end
        end else begin
            if (wr_hit_i && wr_bit_i) begin
                st_d.pend = 1'b1;
            end else if (ack_i) begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/ipi_read_rsp.sv
module ipi_read_rsp
    import ipi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 1,
    parameter swi_mode_e   MODE      = MODE_MACHINE
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rd_req_i,
    input  logic [NUM_HARTS-1:0] rd_hit_i,
    input  logic [NUM_HARTS-1:0] pend_i,
    output logic                 rsp_valid_o,
    output logic [DATA_W-1:0]    rsp_rdata_o
);

    rsp_t rsp_d, rsp_q;
    logic hit_bit;

    always_comb begin
        hit_bit    = |(rd_hit_i & pend_i);
        rsp_d      = '0;
        rsp_d.valid = rd_req_i;
        if (rd_req_i && (MODE == MODE_MACHINE)) begin
            rsp_d.data[0] = hit_bit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_rdata_o = rsp_q.data;

endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 1,
    parameter int unsigned ADDR_W    = 12,
    parameter swi_mode_e   MODE      = MODE_MACHINE
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [31:0]          req_wdata_i,
    input  logic [3:0]           req_be_i,
    output logic                 rsp_valid_o,
    output logic [31:0]          rsp_rdata_o,
    input  logic [NUM_HARTS-1:0] ack_i,
    output logic [NUM_HARTS-1:0] swi_o
);

    logic [NUM_HARTS-1:0] wr_hit;
    logic [NUM_HARTS-1:0] rd_hit;
    logic [NUM_HARTS-1:0] pend;
    logic                 rd_req;
    logic [30:0]          unused_wdata_hi;

    assign unused_wdata_hi = req_wdata_i[31:1];
    assign rd_req          = req_valid_i & ~req_write_i;

    ipi_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_be_i    (req_be_i),
        .wr_hit_o    (wr_hit),
        .rd_hit_o    (rd_hit)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cell
        ipi_pend_cell #(
            .MODE (MODE)
        ) u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wr_hit_i (wr_hit[h]),
            .wr_bit_i (req_wdata_i[0]),
            .ack_i    (ack_i[h]),
            .pend_o   (pend[h])
        );
    end

    ipi_read_rsp #(
        .NUM_HARTS (NUM_HARTS),
        .MODE      (MODE)
    ) u_rsp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_req_i    (rd_req),
        .rd_hit_i    (rd_hit),
        .pend_i      (pend),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

    assign swi_o = pend;

endmodule

// File: rtl/ipi_doorbell_chk.sv
module ipi_doorbell_chk
    import ipi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 1,
    parameter int unsigned ADDR_W    = 12,
    parameter swi_mode_e   MODE      = MODE_MACHINE
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 req_valid_i,
    input logic                 req_write_i,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic [3:0]           req_be_i,
    input logic                 rsp_valid_o,
    input logic [31:0]          rsp_rdata_o,
    input logic [NUM_HARTS-1:0] ack_i,
    input logic [NUM_HARTS-1:0] swi_o
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i) |=> rsp_valid_o); // R4

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o); // R4

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (rsp_rdata_o[31:1] == 31'd0)); // R4

    AST_MISALIGNED_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && (req_addr_i[1:0] != 2'b00) && (ack_i == '0))
        |=> $stable(swi_o)); // R5

    AST_PARTIAL_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && (req_be_i != 4'hF) && (ack_i == '0))
        |=> $stable(swi_o)); // R6

    if (MODE == MODE_SUPERVISOR) begin : g_sup
        AST_SUP_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rsp_valid_o |-> (rsp_rdata_o == 32'd0)); // R8

        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            AST_SUP_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (swi_o[h] && !ack_i[h]) |=> swi_o[h]); // R7
        end
    end else begin : g_mach
        AST_MACH_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(req_valid_i && req_write_i) |=> $stable(swi_o)); // R10
    end

endmodule

bind ipi_doorbell ipi_doorbell_chk #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .MODE      (MODE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_be_i    (req_be_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .ack_i       (ack_i),
    .swi_o       (swi_o)
);

// File: tb/ipi_doorbell_tb_top.sv
module ipi_doorbell_tb_top;
    import ipi_pkg::*;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NH         = 4;
    localparam int unsigned AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = 4'h0;
    logic [NH-1:0] ack_m = '0;
    logic [NH-1:0] ack_s = '0;

    logic          rsp_valid_m, rsp_valid_s;
    logic [31:0]   rdata_m, rdata_s;
    logic [NH-1:0] swi_m, swi_s;

    int checks = 0;
    int fails  = 0;

    logic [NH-1:0] model_m = '0;
    logic [NH-1:0] model_s = '0;

    logic [31:0] exp_m_q[$];
    logic [31:0] exp_s_q[$];
    string       tag_m_q[$];
    string       tag_s_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_doorbell #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(MODE_MACHINE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
        .rsp_valid_o(rsp_valid_m), .rsp_rdata_o(rdata_m), .ack_i(ack_m), .swi_o(swi_m));

    ipi_doorbell #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(MODE_SUPERVISOR)) dut_sup_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
        .rsp_valid_o(rsp_valid_s), .rsp_rdata_o(rdata_s), .ack_i(ack_s), .swi_o(swi_s));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid_m) begin
                if (exp_m_q.size() == 0) check("R4 unexpected machine response", 32'd1, 32'd0);
                else check(tag_m_q.pop_front(), rdata_m, exp_m_q.pop_front());
            end
            if (rsp_valid_s) begin
                if (exp_s_q.size() == 0) check("R4 unexpected supervisor response", 32'd1, 32'd0);
                else check(tag_s_q.pop_front(), rdata_s, exp_s_q.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus, expected state and responses computed from the requirements
    task automatic drive(input bit do_req, input bit wr, input logic [AW-1:0] addr,
                         input logic [31:0] data, input logic [3:0] be,
                         input logic [NH-1:0] am, input logic [NH-1:0] as, input string tag);
        bit ok;
        int idx;
        @(negedge clk);
        req_valid = do_req; req_write = wr; req_addr = addr;
        req_wdata = data;   req_be = be;    ack_m = am; ack_s = as;
        idx = int'(addr >> 2);
        ok  = do_req && (addr[1:0] == 2'b00) && (idx < NH) && (be == 4'hF);
        if (do_req && !wr) begin
            exp_m_q.push_back(ok ? {31'd0, model_m[idx]} : 32'd0);
            exp_s_q.push_back(32'd0);
            tag_m_q.push_back({tag, " machine read"});
            tag_s_q.push_back({tag, " supervisor read (R8)"});
        end
        for (int h = 0; h < NH; h++) begin
            bit hit = ok && wr && (idx == h);
            if (hit) model_m[h] = data[0];
            if (hit && data[0]) model_s[h] = 1'b1;
            else if (as[h]) model_s[h] = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; ack_m = '0; ack_s = '0;
        check({tag, " machine swi"}, 32'(swi_m), 32'(model_m));
        check({tag, " supervisor swi"}, 32'(swi_s), 32'(model_s));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check("watchdog expired", 32'd1, 32'd0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 machine swi", 32'(swi_m), 32'd0);
        check("R1 supervisor swi", 32'(swi_s), 32'd0);
        check("R1 rsp_valid", {30'd0, rsp_valid_m, rsp_valid_s}, 32'd0);
        rst_n = 1'b1;

        drive(1, 1, 8'd8,  32'hA5A5_A5A5, 4'hF, '0, '0, "R2 R11 set hart2 upper bits noise");
        drive(1, 0, 8'd8,  32'h0,         4'hF, '0, '0, "R4 read hart2 set");
        drive(1, 0, 8'd4,  32'h0,         4'hF, '0, '0, "R4 read hart1 clear");
        drive(1, 1, 8'd8,  32'hFFFF_FFFE, 4'hF, '0, '0, "R3 R7 write zero hart2");
        drive(1, 0, 8'd8,  32'h0,         4'hF, '0, '0, "R3 read hart2 after clear");
        drive(1, 1, 8'd0,  32'h1,         4'hF, '0, '0, "R2 set hart0");
        drive(1, 1, 8'd12, 32'h1,         4'hF, '0, '0, "R2 set hart3");
        drive(1, 1, 8'd5,  32'h1,         4'hF, '0, '0, "R5 misaligned write");
        drive(1, 1, 8'd6,  32'h0,         4'hF, '0, '0, "R5 misaligned clear write");
        drive(1, 1, 8'd16, 32'h1,         4'hF, '0, '0, "R5 out of range write");
        drive(1, 0, 8'd16, 32'h0,         4'hF, '0, '0, "R5 out of range read");
        drive(1, 0, 8'd2,  32'h0,         4'hF, '0, '0, "R5 misaligned read");
        drive(1, 1, 8'd4,  32'h1,         4'h1, '0, '0, "R6 partial set write");
        drive(1, 1, 8'd0,  32'h0,         4'h7, '0, '0, "R6 partial clear write");
        drive(1, 0, 8'd0,  32'h0,         4'h3, '0, '0, "R6 partial read");
        drive(0, 0, 8'd0,  32'h0,         4'h0, 4'hF, 4'b1000, "R9 R10 ack without set");
        drive(1, 1, 8'd4,  32'h1,         4'hF, 4'hF, 4'b0011, "R9 set wins over ack");
        drive(1, 0, 8'd0,  32'h0,         4'hF, '0, '0, "R4 read hart0");
        drive(1, 0, 8'd4,  32'h0,         4'hF, '0, '0, "R4 read hart1");
        drive(1, 0, 8'd12, 32'h0,         4'hF, '0, '0, "R4 read hart3");
        drive(0, 0, 8'd0,  32'h0,         4'h0, '0, '0, "R4 drain");
        check("R4 scoreboard drained", 32'(exp_m_q.size() + exp_s_q.size()), 32'd0);
        report();
    end

endmodule